// File: doc/BRIEF.md
# Inter-processor interrupt destination router

This block turns a 64-bit interrupt command, written by one source processor as a high and a low 32-bit word, into a set of receiving processors. There are up to `NUM_TGT` of them. Each receiving processor supplies a physical ID byte, a logical ID byte, a bit that chooses flat or cluster logical format, and two status bits: initialised and enabled. Writing the low word fires the command at once. One clock later the block presents a one-cycle send strobe together with the target mask, the vector, the delivery mode, the trigger mode and the level flag.

Destinations can be given by a shorthand (self, everyone, everyone but the sender) or by the 8-bit destination byte. The byte is matched in one of three ways: physically against the ID, as a flat logical bitmask, or as a logical cluster plus member bits. For lowest-priority delivery, exactly one processor is picked from the matching set. The pick is round-robin, and a separate pointer is kept for every vector value, so interrupt streams on different vectors rotate independently.

Top module: `ipi_route`

## Requirements
- R1: After reset, `send_vld` is 0, both command readbacks are 0, and every per-vector round-robin pointer holds target 0.
- R2: A cycle with `cmd_lo_we` high produces `send_vld` high in the next cycle only, carrying the vector (word bits 7:0), delivery mode (bits 10:8), level (bit 14) and trigger (bit 15). The low readback equals the written word with bit 12 forced to 0.
- R3: A high-word write keeps only bits 31:24 (the destination byte), reads back with bits 23:0 zero, and produces no send strobe.
- R4: With shorthand 0 and destination mode bit 11 = 0 (physical), a target matches when its physical ID equals the destination byte.
- R5: With shorthand 0, bit 11 = 1 and the target's cluster bit at 0 (flat), a target matches when its logical ID AND the destination byte is nonzero.
- R6: With shorthand 0, bit 11 = 1 and the cluster bit at 1, a target matches when the upper nibbles of its logical ID and the destination are equal and the lower nibbles share a set bit.
- R7: Shorthand bits 19:18 = 1 selects only the source `src_idx`, 2 selects all targets, and 3 selects all but the source. In each of these cases the destination byte is ignored.
- R8: For delivery modes 0 (fixed) and 1 (lowest priority), targets whose enable bit is 0 are removed from the mask. Other modes (such as 4) are not gated by enable.
- R9: For mode 1, the search starts at the target after the vector's stored pointer and wraps. It skips targets that are not initialised, picks the first match, and stores that target as the vector's new pointer.
- R10: Mode 1 with physical destination mode, or with no initialised matching target, gives an empty mask and leaves the pointer unchanged.
- R11: Pointers of different vectors are independent; lowest-priority sends on one vector do not move another vector's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lo_we | input | 1 | Write strobe for the low command word; fires the send |
| cmd_hi_we | input | 1 | Write strobe for the high command word |
| cmd_wdata | input | 32 | Write data for either command word |
| src_idx | input | $clog2(NUM_TGT) | Index of the sending processor |
| tgt_phys_id | input | NUM_TGT*8 | Physical ID byte per target, target i at bits 8i+7:8i |
| tgt_log_id | input | NUM_TGT*8 | Logical ID byte per target |
| tgt_cluster | input | NUM_TGT | Per target: 1 cluster logical format, 0 flat |
| tgt_init | input | NUM_TGT | Per target initialised flag |
| tgt_en | input | NUM_TGT | Per target enabled flag |
| cmd_lo_rd | output | 32 | Stored low word, bit 12 always 0 |
| cmd_hi_rd | output | 32 | Stored high word, only bits 31:24 nonzero |
| send_vld | output | 1 | One-cycle send strobe |
| send_mask | output | NUM_TGT | Accepting targets |
| send_vec | output | 8 | Vector |
| send_mode | output | 3 | Delivery mode |
| send_trig | output | 1 | Trigger mode, 1 level |
| send_level | output | 1 | Level-assert flag |

## Verification
A corrupted round-robin pointer does not show up on the send that uses it. It shows up on the next lowest-priority send for that same vector, which picks a different one-hot target than the rotation predicts. The bench therefore issues long runs on one vector, and interleaves a second vector to expose pointers that are shared or overwritten. Match and gating errors show up on the mask exactly one cycle after the low-word write, because no other state lies between the command and the strobe.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;
   localparam int VEC_W  = 8;
   localparam int DEST_W = 8;
   localparam int MODE_W = 3;
   localparam int NUM_VEC = 1 << VEC_W;

   localparam logic [MODE_W-1:0] MODE_FIXED  = 3'd0;
   localparam logic [MODE_W-1:0] MODE_LOWEST = 3'd1;

   localparam int PEND_BIT = 12;

   typedef enum logic [1:0] {
      SH_DEST   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef struct packed {
      logic [VEC_W-1:0]  vec;
      logic [MODE_W-1:0] mode;
      logic              logical;
      logic              level;
      logic              trig;
      shorthand_e        sh;
   } cmd_t;

   function automatic cmd_t split_lo(input logic [31:0] w);
      cmd_t c;
      c.vec     = w[7:0];
      c.mode    = w[10:8];
      c.logical = w[11];
      c.level   = w[14];
      c.trig    = w[15];
      c.sh      = shorthand_e'(w[19:18]);
      return c;
   endfunction
endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
   import ipi_route_pkg::*;
#(
   parameter int NUM_TGT    = 8,
   parameter bit CLUSTER_EN = 1'b1,
   localparam int IDX_W     = $clog2(NUM_TGT)
) (
   input  shorthand_e                  sh,
   input  logic                        logical,
   input  logic [DEST_W-1:0]           dest,
   input  logic [IDX_W-1:0]            src_idx,
   input  logic [NUM_TGT*DEST_W-1:0]   phys_ids,
   input  logic [NUM_TGT*DEST_W-1:0]   log_ids,
   input  logic [NUM_TGT-1:0]          cluster,
   output logic [NUM_TGT-1:0]          hit
);
   localparam int NIB = DEST_W / 2;

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
      logic [DEST_W-1:0] pid, lid;
      logic              flat_hit, clus_hit, dest_hit, is_src;

      assign pid      = phys_ids[i*DEST_W +: DEST_W];
      assign lid      = log_ids[i*DEST_W +: DEST_W];
      assign flat_hit = |(lid & dest);
      assign is_src   = (src_idx == IDX_W'(i));

      if (CLUSTER_EN) begin : g_clus
         assign clus_hit = (lid[DEST_W-1:NIB] == dest[DEST_W-1:NIB]) &&
                           (|(lid[NIB-1:0] & dest[NIB-1:0]));
      end else begin : g_flat_only
         assign clus_hit = flat_hit;
      end

      always_comb begin
         if (!logical)        dest_hit = (pid == dest);
         else if (cluster[i]) dest_hit = clus_hit;
         else                 dest_hit = flat_hit;
      end

      always_comb begin
         unique case (sh)
            SH_DEST:   hit[i] = dest_hit;
            SH_SELF:   hit[i] = is_src;
            SH_ALL:    hit[i] = 1'b1;
            SH_OTHERS: hit[i] = !is_src;
         endcase
      end
   end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick
   import ipi_route_pkg::*;
#(
   parameter int NUM_TGT = 8,
   localparam int IDX_W  = $clog2(NUM_TGT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VEC_W-1:0]   vec,
   input  logic [NUM_TGT-1:0] cand,
   input  logic               commit,
   output logic [NUM_TGT-1:0] pick_oh,
   output logic               pick_any
);
   logic [IDX_W-1:0] ptr_q [NUM_VEC];
   logic [IDX_W-1:0] ptr_cur;
   logic [IDX_W-1:0] pick_idx;

   assign ptr_cur = ptr_q[vec];

   always_comb begin
      pick_any = 1'b0;
      pick_idx = ptr_cur;
      for (int k = 1; k <= NUM_TGT; k++) begin
         if (!pick_any && cand[(int'(ptr_cur) + k) % NUM_TGT]) begin
            pick_any = 1'b1;
            pick_idx = IDX_W'((int'(ptr_cur) + k) % NUM_TGT);
         end
      end
      pick_oh = '0;
      if (pick_any) pick_oh[pick_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) ptr_q[v] <= '0;
      end else if (commit && pick_any) begin
         ptr_q[vec] <= pick_idx;
      end
   end
endmodule

// File: rtl/ipi_route.sv
module ipi_route
   import ipi_route_pkg::*;
#(
   parameter int NUM_TGT    = 8,
   parameter bit CLUSTER_EN = 1'b1,
   localparam int IDX_W     = $clog2(NUM_TGT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_lo_we,
   input  logic                       cmd_hi_we,
   input  logic [31:0]                cmd_wdata,
   input  logic [IDX_W-1:0]           src_idx,
   input  logic [NUM_TGT*DEST_W-1:0]  tgt_phys_id,
   input  logic [NUM_TGT*DEST_W-1:0]  tgt_log_id,
   input  logic [NUM_TGT-1:0]         tgt_cluster,
   input  logic [NUM_TGT-1:0]         tgt_init,
   input  logic [NUM_TGT-1:0]         tgt_en,
   output logic [31:0]                cmd_lo_rd,
   output logic [31:0]                cmd_hi_rd,
   output logic                       send_vld,
   output logic [NUM_TGT-1:0]         send_mask,
   output logic [VEC_W-1:0]           send_vec,
   output logic [MODE_W-1:0]          send_mode,
   output logic                       send_trig,
   output logic                       send_level
);
   if (NUM_TGT < 2 || NUM_TGT > 64) begin : g_bad_num_tgt
      $error("ipi_route: NUM_TGT must lie in 2..64");
   end

   logic [31:0]        lo_q;
   logic [DEST_W-1:0]  dest_q;
   cmd_t               cmd;
   logic [NUM_TGT-1:0] hit, cand, pick_oh, mask_n;
   logic               pick_any, is_lowest, gated;

   assign cmd       = split_lo(cmd_wdata);
   assign is_lowest = (cmd.mode == MODE_LOWEST);
   assign gated     = (cmd.mode == MODE_FIXED) || is_lowest;
   assign cand      = (is_lowest && cmd.logical) ? (hit & tgt_init) : '0;

   ipi_dest_match #(.NUM_TGT(NUM_TGT), .CLUSTER_EN(CLUSTER_EN)) u_match (
      .sh       (cmd.sh),
      .logical  (cmd.logical),
      .dest     (dest_q),
      .src_idx  (src_idx),
      .phys_ids (tgt_phys_id),
      .log_ids  (tgt_log_id),
      .cluster  (tgt_cluster),
      .hit      (hit)
   );

   ipi_rr_pick #(.NUM_TGT(NUM_TGT)) u_rr (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec      (cmd.vec),
      .cand     (cand),
      .commit   (cmd_lo_we && is_lowest),
      .pick_oh  (pick_oh),
      .pick_any (pick_any)
   );

   always_comb begin
      mask_n = is_lowest ? (pick_any ? pick_oh : '0) : hit;
      if (gated) mask_n = mask_n & tgt_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q       <= '0;
         dest_q     <= '0;
         send_vld   <= 1'b0;
         send_mask  <= '0;
         send_vec   <= '0;
         send_mode  <= '0;
         send_trig  <= 1'b0;
         send_level <= 1'b0;
      end else begin
         send_vld <= cmd_lo_we;
         if (cmd_hi_we) dest_q <= cmd_wdata[31:24];
         if (cmd_lo_we) begin
            lo_q       <= cmd_wdata & ~(32'd1 << PEND_BIT);
            send_mask  <= mask_n;
            send_vec   <= cmd.vec;
            send_mode  <= cmd.mode;
            send_trig  <= cmd.trig;
            send_level <= cmd.level;
         end
      end
   end

   assign cmd_lo_rd = lo_q;
   assign cmd_hi_rd = {dest_q, 24'd0};
endmodule

// File: rtl/ipi_route_chk.sv
module ipi_route_chk
   import ipi_route_pkg::*;
#(
   parameter int NUM_TGT = 8,
   localparam int IDX_W  = $clog2(NUM_TGT)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_lo_we,
   input logic                cmd_hi_we,
   input logic [31:0]         cmd_wdata,
   input logic [IDX_W-1:0]    src_idx,
   input logic [NUM_TGT-1:0]  tgt_en,
   input logic [31:0]         cmd_lo_rd,
   input logic [31:0]         cmd_hi_rd,
   input logic                send_vld,
   input logic [NUM_TGT-1:0]  send_mask,
   input logic [MODE_W-1:0]   send_mode
);
   p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_lo_we |=> send_vld);

   p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_lo_we |=> !send_vld);

   p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_lo_rd[PEND_BIT] == 1'b0);

   p_hi_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hi_rd[23:0] == 24'd0);

   p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hi_we |=> cmd_hi_rd[31:24] == $past(cmd_wdata[31:24]));

   p_self_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_we && cmd_wdata[19:18] == 2'd1) |=>
         (send_mask & ~(NUM_TGT'(1) << $past(src_idx))) == '0);

   p_en_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_we && cmd_wdata[10:9] == 2'b00) |=>
         (send_mask & ~$past(tgt_en)) == '0);

   p_one_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (send_vld && send_mode == MODE_LOWEST) |-> $onehot0(send_mask));
endmodule

bind ipi_route ipi_route_chk #(.NUM_TGT(NUM_TGT)) u_chk (.*);

// File: tb/ipi_route_bench.sv
`timescale 1ns/1ps
module ipi_route_bench;
   localparam int NT = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_lo_we = 1'b0, cmd_hi_we = 1'b0;
   logic [31:0]     cmd_wdata = '0;
   logic [2:0]      src_idx = '0;
   logic [NT*8-1:0] tgt_phys_id, tgt_log_id;
   logic [NT-1:0]   tgt_cluster = '0, tgt_init = '1, tgt_en = '1;
   logic [31:0]     cmd_lo_rd, cmd_hi_rd;
   logic            send_vld, send_trig, send_level;
   logic [NT-1:0]   send_mask;
   logic [7:0]      send_vec;
   logic [2:0]      send_mode;

   logic [7:0] pid [NT];
   logic [7:0] lid [NT];
   int         ptr_m [256];
   logic [7:0] dest_m = '0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   typedef struct {
      logic [NT-1:0] mask;
      logic [7:0]    vec;
      logic [2:0]    mode;
      logic          trig;
      logic          level;
      string         req;
   } exp_t;
   exp_t exp_q [$];

   for (genvar i = 0; i < NT; i++) begin : g_pack
      assign tgt_phys_id[i*8 +: 8] = pid[i];
      assign tgt_log_id[i*8 +: 8]  = lid[i];
   end

   always #5 clk = ~clk;

   ipi_route #(.NUM_TGT(NT)) u_ipi_route (.*);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NT-1:0] model_hit(input logic [1:0] sh, input logic lg, input logic [7:0] d);
      logic [NT-1:0] m;
      for (int i = 0; i < NT; i++) begin
         case (sh)
            2'd1: m[i] = (i == int'(src_idx));
            2'd2: m[i] = 1'b1;
            2'd3: m[i] = (i != int'(src_idx));
            default: begin
               if (!lg)                 m[i] = (pid[i] == d);
               else if (tgt_cluster[i]) m[i] = (lid[i][7:4] == d[7:4]) && ((lid[i][3:0] & d[3:0]) != 0);
               else                     m[i] = ((lid[i] & d) != 0);
            end
         endcase
      end
      return m;
   endfunction

   // monitor: pops the scoreboard whenever a send strobe appears
   always @(negedge clk) begin
      if (rst_n && send_vld) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected strobe", 64'(send_vld), 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({send_mask, send_vec, send_mode, send_trig, send_level} ==
                  {e.mask, e.vec, e.mode, e.trig, e.level}, e.req,
                  64'({send_mask, send_vec, send_mode, send_trig, send_level}),
                  64'({e.mask, e.vec, e.mode, e.trig, e.level}));
         end
      end
   end

   task automatic wr_hi(input logic [31:0] w);
      @(negedge clk);
      cmd_wdata = w; cmd_hi_we = 1'b1;
      @(negedge clk);
      cmd_hi_we = 1'b0;
      dest_m = w[31:24];
   endtask

   // driver: computes the expected send and pushes it before firing
   task automatic send(input logic [31:0] w, input string req);
      exp_t e;
      logic [NT-1:0] m;
      logic [7:0] v;
      v = w[7:0];
      m = model_hit(w[19:18], w[11], dest_m);
      if (w[10:8] == 3'd1) begin
         logic [NT-1:0] c;
         c = (w[11]) ? (m & tgt_init) : '0;
         m = '0;
         for (int k = 1; k <= NT; k++) begin
            int j;
            j = (ptr_m[v] + k) % NT;
            if (m == '0 && c[j]) begin
               m[j] = 1'b1;
               ptr_m[v] = j;
            end
         end
      end
      if (w[10:8] <= 3'd1) m = m & tgt_en;
      e.mask = m; e.vec = v; e.mode = w[10:8]; e.trig = w[15]; e.level = w[14]; e.req = req;
      @(negedge clk);
      exp_q.push_back(e);
      cmd_wdata = w; cmd_lo_we = 1'b1;
      @(negedge clk);
      cmd_lo_we = 1'b0;
   endtask

   function automatic logic [31:0] lo(input logic [7:0] vec, input logic [2:0] mode,
                                      input logic lg, input logic [1:0] sh);
      return {12'd0, sh, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, lg, mode, vec};
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) ptr_m[i] = 0;
      for (int i = 0; i < NT; i++) begin
         pid[i] = 8'h10 + 8'(i);
         lid[i] = 8'(1 << i);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(send_vld == 1'b0, "R1 send_vld at reset", 64'(send_vld), 0);
      check(cmd_lo_rd == 0, "R1 low readback at reset", 64'(cmd_lo_rd), 0);
      check(cmd_hi_rd == 0, "R1 high readback at reset", 64'(cmd_hi_rd), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 high word masking, no strobe
      wr_hi(32'hAB_FF_FF_FF);
      check(cmd_hi_rd == 32'hAB00_0000, "R3 high readback", 64'(cmd_hi_rd), 64'hAB00_0000);
      check(send_vld == 1'b0, "R3 no strobe on high write", 64'(send_vld), 0);

      // R4 physical, R2 field transport and pending bit
      wr_hi(32'h1300_0000);
      send(lo(8'h40, 3'd0, 1'b0, 2'd0) | 32'h0000_D000, "R4 physical id 0x13 / R2 fields");
      check(cmd_lo_rd == (lo(8'h40, 3'd0, 1'b0, 2'd0) | 32'h0000_C000), "R2 pending bit cleared",
            64'(cmd_lo_rd), 64'(lo(8'h40, 3'd0, 1'b0, 2'd0) | 32'h0000_C000));
      wr_hi(32'h7700_0000);
      send(lo(8'h41, 3'd0, 1'b0, 2'd0), "R4 physical no match");

      // R5 flat logical
      wr_hi(32'h0500_0000);
      send(lo(8'h42, 3'd0, 1'b1, 2'd0) | 32'h0000_8000, "R5 flat dest 0x05");
      wr_hi(32'hF000_0000);
      send(lo(8'h43, 3'd0, 1'b1, 2'd0), "R5 flat dest 0xF0");

      // R8 enable gating
      tgt_en[2] = 1'b0;
      wr_hi(32'h0500_0000);
      send(lo(8'h44, 3'd0, 1'b1, 2'd0), "R8 fixed gated by enable");
      send(lo(8'h45, 3'd4, 1'b1, 2'd0), "R8 mode 4 not gated");
      tgt_en[2] = 1'b1;

      // R7 shorthands ignore destination
      src_idx = 3'd2;
      wr_hi(32'h0100_0000);
      send(lo(8'h46, 3'd0, 1'b0, 2'd1), "R7 self");
      send(lo(8'h47, 3'd0, 1'b0, 2'd2), "R7 all including self");
      send(lo(8'h48, 3'd0, 1'b1, 2'd3), "R7 all but self");

      // R9 round robin with skip of target 4
      tgt_init[4] = 1'b0;
      wr_hi(32'hFF00_0000);
      for (int n = 0; n < 9; n++) begin
         send(lo(8'h50, 3'd1, 1'b1, 2'd0), "R9 round robin vec 0x50");
         if (n == 3) send(lo(8'h51, 3'd1, 1'b1, 2'd0), "R11 independent vec 0x51");
      end
      send(lo(8'h51, 3'd1, 1'b1, 2'd0), "R11 vec 0x51 second pick");

      // R10 physical lowest and empty set leave the pointer
      send(lo(8'h50, 3'd1, 1'b0, 2'd0), "R10 lowest in physical mode");
      wr_hi(32'h1000_0000);
      send(lo(8'h50, 3'd1, 1'b1, 2'd0), "R10 only uninitialised target matches");
      wr_hi(32'hFF00_0000);
      send(lo(8'h50, 3'd1, 1'b1, 2'd0), "R10 pointer kept after empty pick");
      tgt_init[4] = 1'b1;

      // R6 cluster format
      tgt_cluster = '1;
      for (int i = 0; i < NT; i++) lid[i] = {4'(i / 4), 4'(1 << (i % 4))};
      wr_hi(32'h1300_0000);
      send(lo(8'h60, 3'd0, 1'b1, 2'd0), "R6 cluster 1 members 0,1");
      wr_hi(32'h0C00_0000);
      send(lo(8'h61, 3'd0, 1'b1, 2'd0), "R6 cluster 0 members 2,3");
      wr_hi(32'h2F00_0000);
      send(lo(8'h62, 3'd0, 1'b1, 2'd0), "R6 absent cluster");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R2 every send produced a strobe", 64'(exp_q.size()), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule